// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block turns a slow timekeeping strobe (one pulse per cycle of a 32.768 kHz base, delivered as a clock enable on the system clock) into periodic interrupt events. A free-running 15-bit count of base cycles runs from reset and does not stop. A 4-bit rate code selects a power-of-two period, and an enable bit gates the events. Each event is a single system-clock pulse. The surrounding register logic uses it to set its interrupt-request and periodic flags and to raise the interrupt line.

Events are aligned to the free-running count. An event fires whenever the count reaches a multiple of the selected period, wherever that count stood when the source was enabled. The rate code and the enable are sampled again on every strobe, so a change takes effect at once and the divider needs no restart.

Top module: `periodic_rate_div`

## Requirements
- R1: While `rst_n` is low, `event_pulse` is 0, and the base-cycle count returns to zero, so the first strobe after reset brings the count to 1.
- R2: The base-cycle count advances by one only in a clock cycle with `tick_en` high. A clock cycle without a strobe never produces an event.
- R3: A `rate_code` of 0, or a low `pie_en`, produces no event.
- R4: For `rate_code` values 3 to 15, the period is 2^(`rate_code`-1) strobes: 4 strobes for code 3 and 16384 strobes for code 15.
- R5: Code 1 behaves as code 8, giving a period of 128 strobes. Code 2 behaves as code 9, giving a period of 256 strobes.
- R6: An event occurs on the strobe that makes the count since reset (modulo 32768) an exact multiple of the period. This holds no matter when the source was enabled.
- R7: The code and enable present during a strobe decide that strobe. A change of code never yields an event from the old period.
- R8: `event_pulse` rises in the clock cycle after the deciding strobe and stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe per 32.768 kHz base cycle |
| rate_code | input | 4 | Period selection code |
| pie_en | input | 1 | Periodic event enable |
| event_pulse | output | 1 | One-cycle periodic event |

## Verification
The divider is tried with every class of code: the plain codes at both ends (3 and 15), mid codes, the two remapped codes, and code 0 alongside a low enable. Counting events over a fixed strobe run separates a wrong exponent from a wrong remap. Strobes with idle cycles between them show whether the count moves without a strobe. Enabling partway through a period, and switching code just before an old-period boundary, separate count-aligned events from events delayed from the enable, and expose any stale event left over from the old period.

// File: rtl/prd_pkg.sv
package prd_pkg;
    localparam int CNT_W  = 15;
    localparam int CODE_W = 4;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } presc_state_t;

    typedef struct packed {
        logic fire;
    } out_state_t;
endpackage

// File: rtl/prd_prescaler.sv
module prd_prescaler
    import prd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_d
);
    presc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_en) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.count;
    assign count_d = st_d.count;

    // R2: the count may only change after a strobe
    a_r2_count_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(st_q.count));
endmodule

// File: rtl/prd_rate_decode.sv
module prd_rate_decode
    import prd_pkg::*;
(
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie_en,
    output logic              active,
    output logic [CNT_W-1:0]  low_mask
);
    logic [CODE_W-1:0] eff_code;
    logic [CODE_W-1:0] exp_bits;

    always_comb begin
        if (rate_code == CODE_W'(1) || rate_code == CODE_W'(2)) begin
            eff_code = rate_code + CODE_W'(7);
        end else begin
            eff_code = rate_code;
        end
        exp_bits = (eff_code == '0) ? '0 : eff_code - 1'b1;
        active   = pie_en && (rate_code != '0);
    end

    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign low_mask[i] = (exp_bits > CODE_W'(i));
    end
endmodule

// File: rtl/periodic_rate_div.sv
module periodic_rate_div
    import prd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie_en,
    output logic              event_pulse
);
    logic [CNT_W-1:0] count_q, count_d, low_mask;
    logic             active;
    out_state_t       o_d, o_q;

    prd_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count_q (count_q),
        .count_d (count_d)
    );

    prd_rate_decode u_dec (
        .rate_code (rate_code),
        .pie_en    (pie_en),
        .active    (active),
        .low_mask  (low_mask)
    );

    always_comb begin
        o_d.fire = tick_en && active && ((count_d & low_mask) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign event_pulse = o_q.fire;

    // R8: no two events back to back
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |=> !event_pulse);
    // R2: an event always follows a strobe
    a_r2_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> $past(tick_en));
    // R3: a disabled or zero-code source stays silent
    a_r3_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> $past(active));
    // R6: events land on period multiples of the count
    a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> ((count_q & $past(low_mask)) == '0));
endmodule

// File: tb/periodic_rate_div_test.sv
module periodic_rate_div_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie_en = 1'b0;
    logic       event_pulse;

    int compared = 0;
    int mismatched = 0;
    int mcnt = 0;
    int ev_seen = 0;
    bit done = 0;

    always #4 clk = ~clk;

    periodic_rate_div uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .rate_code   (rate_code),
        .pie_en      (pie_en),
        .event_pulse (event_pulse)
    );

    // row: code, enable, strobe count, expected events
    typedef struct packed {
        logic [3:0]  code;
        logic        en;
        logic [15:0] steps;
        logic [7:0]  events;
    } row_t;

    localparam int NROWS = 11;
    localparam row_t ROWS [NROWS] = '{
        '{4'd3,  1'b1, 16'd20,    8'd5},
        '{4'd6,  1'b1, 16'd100,   8'd3},
        '{4'd1,  1'b1, 16'd300,   8'd2},
        '{4'd2,  1'b1, 16'd600,   8'd2},
        '{4'd8,  1'b1, 16'd300,   8'd2},
        '{4'd9,  1'b1, 16'd600,   8'd2},
        '{4'd4,  1'b1, 16'd33,    8'd4},
        '{4'd15, 1'b1, 16'd16400, 8'd1},
        '{4'd0,  1'b1, 16'd50,    8'd0},
        '{4'd3,  1'b0, 16'd50,    8'd0},
        '{4'd11, 1'b1, 16'd2100,  8'd2}
    };

    function automatic int period_of(input logic [3:0] c);
        int e;
        e = (c == 4'd1 || c == 4'd2) ? int'(c) + 7 : int'(c);
        return 1 << (e - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // starts and ends at a negedge; the output is sampled one edge after the strobe
    task automatic step(input logic t, input string req);
        logic expv;
        tick_en = t;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        if (t) mcnt = (mcnt + 1) % 32768;
        expv = t && pie_en && (rate_code != 4'd0) && ((mcnt % period_of(rate_code)) == 0);
        if (event_pulse) ev_seen++;
        check(event_pulse == expv, req, int'(event_pulse), int'(expv));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(event_pulse == 1'b0, "R1", int'(event_pulse), 0);
        rst_n = 1'b1;
        mcnt = 0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : main
        string tag;
        // table walk: R3, R4, R5 by event totals, R6 per strobe
        for (int r = 0; r < NROWS; r++) begin
            do_reset();
            rate_code = ROWS[r].code;
            pie_en = ROWS[r].en;
            ev_seen = 0;
            for (int s = 0; s < int'(ROWS[r].steps); s++) step(1'b1, "R6");
            if (!ROWS[r].en || ROWS[r].code == 4'd0) tag = "R3";
            else if (ROWS[r].code == 4'd1 || ROWS[r].code == 4'd2) tag = "R5";
            else tag = "R4";
            check(ev_seen == int'(ROWS[r].events), tag, ev_seen, int'(ROWS[r].events));
        end

        // R1: the count restarts at zero, so code 3 fires on the 4th strobe
        do_reset();
        rate_code = 4'd3; pie_en = 1'b1;
        for (int s = 0; s < 3; s++) step(1'b1, "R1");
        step(1'b1, "R1");
        check(event_pulse == 1'b1, "R1", int'(event_pulse), 1);

        // R6: enabled partway; the event comes at count 12, two strobes later
        do_reset();
        rate_code = 4'd3; pie_en = 1'b0;
        for (int s = 0; s < 10; s++) step(1'b1, "R6");
        pie_en = 1'b1;
        step(1'b1, "R6");
        check(event_pulse == 1'b0, "R6", int'(event_pulse), 0);
        step(1'b1, "R6");
        check(event_pulse == 1'b1, "R6", int'(event_pulse), 1);
        // R8: the next cycle is low
        step(1'b0, "R8");
        check(event_pulse == 1'b0, "R8", int'(event_pulse), 0);

        // R7: switching from period 8 to 32 just before count 8 gives no stale event
        do_reset();
        rate_code = 4'd4; pie_en = 1'b1;
        for (int s = 0; s < 7; s++) step(1'b1, "R7");
        rate_code = 4'd6;
        step(1'b1, "R7");
        check(event_pulse == 1'b0, "R7", int'(event_pulse), 0);
        for (int s = 0; s < 24; s++) step(1'b1, "R7");
        check(event_pulse == 1'b1, "R7", int'(event_pulse), 1);

        // R7: switching from period 16 to 4 at count 8 fires at count 12
        do_reset();
        rate_code = 4'd5; pie_en = 1'b1;
        for (int s = 0; s < 8; s++) step(1'b1, "R7");
        rate_code = 4'd3;
        for (int s = 0; s < 4; s++) step(1'b1, "R7");
        check(event_pulse == 1'b1, "R7", int'(event_pulse), 1);

        // R2: idle cycles between strobes neither advance the count nor fire
        do_reset();
        rate_code = 4'd3; pie_en = 1'b1;
        for (int s = 0; s < 12; s++) begin
            step(1'b1, "R2");
            step(1'b0, "R2");
            step(1'b0, "R2");
        end
        check(mcnt == 12, "R2", mcnt, 12);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule